// File: doc/BRIEF.md
# Interrupt Aggregation Controller

The block gathers up to sixteen level-sensitive interrupt request lines and a small bank of mailbox doorbells into a single 32-bit status word. A companion enable word, written over a simple memory-mapped control/status port, masks that status bit by bit. A single registered interrupt line is driven toward a PCI Express endpoint core, for use as a legacy INTx assert level or as the trigger for an MSI request. The block imposes no ordering among pending sources. Software reads the status word and decides which source to service first.

The two kinds of status bit are cleared in different ways. A request bit is a synchronized copy of its input line, so it drops only when the component that raised it withdraws the request. A mailbox bit is sticky. It is set by any write to that mailbox's data register and cleared only when software writes a one to it in the status word.

Status word layout: bits 0 to NUM_REQ-1 are the request lines, and bits 16 to 16+NUM_MBOX-1 are the mailbox doorbells. All other bits are zero. Byte addresses: status at 0x0040, enable at 0x3070, and mailbox i at 0x0900 + 4*i.

Top module: `irq_aggr_ctrl`

## Requirements
- R1: While reset is active and right after it is released, irq_o is 0, csr_rdata is 0, and reads of the status and enable words return 0.
- R2: Status bit i (i < NUM_REQ) equals the level of irq_req_i[i] delayed by two clock edges. It rises and falls with the input.
- R3: A write to the status word (0x0040) never changes the request bits (bits 0 to NUM_REQ-1).
- R4: A write to mailbox i (0x0900 + 4*i, i < NUM_MBOX) stores the 32-bit write data, which is read back at the same address. At the same clock edge it sets status bit 16+i.
- R5: A mailbox status bit stays set until a status-word write carries a 1 in that bit position. Writing a 0 in that position leaves the bit unchanged.
- R6: The enable word at 0x3070 stores the write data masked to the implemented status bits. Unimplemented bits read back as 0.
- R7: irq_o is the OR of (status AND enable) registered once. It rises on the edge after an enabled bit becomes set and falls on the edge after the last one clears.
- R8: A read returns data on csr_rdata at the clock edge that samples csr_read. The value holds until the next read. Unmapped addresses, and mailbox slots at or above NUM_MBOX, read as 0.
- R9: Any number of request and mailbox bits can be set at the same time, and all of them are visible together in the status word with no priority applied.
- R10: Status bits outside the implemented request and mailbox ranges always read as 0.
- R11: A write to a mailbox slot at or above NUM_MBOX has no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_req_i | input | NUM_REQ | Asynchronous level interrupt requests, one per source |
| csr_addr | input | 14 | Byte address of the control/status access |
| csr_read | input | 1 | Read strobe |
| csr_write | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Aggregated interrupt level |

## Verification
The assertions assume that csr_read and csr_write are never active together. They also assume that no write arrives while the internal reset synchronizer is still holding the block in reset. The request-tracking property only starts a few cycles after reset release, so it does not need the input to have been quiet during reset. The stimulus drives one access per transaction from the falling clock edge and keeps the request lines low through reset. It waits several cycles after reset release before the first access.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int unsigned CSR_AW        = 14;
  localparam int unsigned CSR_DW        = 32;
  localparam int unsigned MAX_REQ       = 16;
  localparam int unsigned MAX_MBOX      = 16;
  localparam int unsigned MBOX_BIT_BASE = 16;
  localparam int unsigned MBOX_IDX_W    = 4;

  localparam logic [CSR_AW-1:0] OFS_STATUS = 14'h0040;
  localparam logic [CSR_AW-1:0] OFS_ENABLE = 14'h3070;
  localparam logic [CSR_AW-1:0] OFS_MBOX   = 14'h0900;

  typedef struct packed {
    logic                  st_rd;
    logic                  st_wr;
    logic                  en_rd;
    logic                  en_wr;
    logic                  mb_rd;
    logic                  mb_wr;
    logic [MBOX_IDX_W-1:0] mb_idx;
  } csr_sel_t;

  function automatic logic [CSR_DW-1:0] impl_mask(int unsigned nreq, int unsigned nmbox);
    logic [CSR_DW-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < MAX_REQ; b++)
      if (b < nreq) m[b] = 1'b1;
    for (int unsigned b = 0; b < MAX_MBOX; b++)
      if (b < nmbox) m[MBOX_BIT_BASE + b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] req_async,
  output logic [WIDTH-1:0] req_sync
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q;
    logic meta_d;
    logic sync_q;
    logic sync_d;

    always_comb begin
      meta_d = req_async[g];
      sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= meta_d;
        sync_q <= sync_d;
      end
    end

    assign req_sync[g] = sync_q;
  end
endmodule

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_MBOX = 4
) (
  input  logic [CSR_AW-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output csr_sel_t          sel
);
  logic hit_status;
  logic hit_enable;
  logic hit_mbox_win;
  logic [MBOX_IDX_W-1:0] idx;
  logic idx_ok;

  always_comb begin
    hit_status   = (addr == OFS_STATUS);
    hit_enable   = (addr == OFS_ENABLE);
    hit_mbox_win = (addr[CSR_AW-1:6] == OFS_MBOX[CSR_AW-1:6]) && (addr[1:0] == 2'b00);
    idx          = addr[5:2];
    idx_ok       = ({1'b0, idx} < (MBOX_IDX_W+1)'(NUM_MBOX));

    sel.st_rd  = rd & hit_status;
    sel.st_wr  = wr & hit_status;
    sel.en_rd  = rd & hit_enable;
    sel.en_wr  = wr & hit_enable;
    sel.mb_rd  = rd & hit_mbox_win & idx_ok;
    sel.mb_wr  = wr & hit_mbox_win & idx_ok;
    sel.mb_idx = idx;
  end
endmodule

// File: rtl/irq_mbox_bank.sv
module irq_mbox_bank
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_MBOX = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [MBOX_IDX_W-1:0]      wr_idx,
  input  logic [CSR_DW-1:0]          wr_data,
  input  logic [NUM_MBOX-1:0]        clr_mask,
  output logic [NUM_MBOX-1:0]        pend,
  output logic [NUM_MBOX*CSR_DW-1:0] data_flat
);
  for (genvar g = 0; g < NUM_MBOX; g++) begin : g_box
    logic              hit;
    logic              pend_q;
    logic              pend_d;
    logic              pend_ce;
    logic [CSR_DW-1:0] data_q;
    logic [CSR_DW-1:0] data_d;

    always_comb begin
      hit     = wr_en && (wr_idx == MBOX_IDX_W'(g));
      pend_ce = hit | clr_mask[g];
      // a doorbell in the same cycle as a clear wins
      pend_d  = hit | (pend_q & ~clr_mask[g]);
      data_d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        data_q <= '0;
      end else begin
        if (pend_ce) pend_q <= pend_d;
        if (hit)     data_q <= data_d;
      end
    end

    assign pend[g] = pend_q;
    assign data_flat[g*CSR_DW +: CSR_DW] = data_q;
  end
endmodule

// File: rtl/irq_aggr_ctrl.sv
module irq_aggr_ctrl
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_REQ  = 16,
  parameter int unsigned NUM_MBOX = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] irq_req_i,
  input  logic [CSR_AW-1:0]  csr_addr,
  input  logic               csr_read,
  input  logic               csr_write,
  input  logic [CSR_DW-1:0]  csr_wdata,
  output logic [CSR_DW-1:0]  csr_rdata,
  output logic               irq_o
);
  localparam logic [CSR_DW-1:0] IMPL_MASK = impl_mask(NUM_REQ, NUM_MBOX);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q;
  logic rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_q    <= rst_s1_q;
    end
  end

  logic [NUM_REQ-1:0] req_sync;
  irq_req_sync #(.WIDTH(NUM_REQ)) u_sync (
    .clk       (clk),
    .rst_n     (rst_q),
    .req_async (irq_req_i),
    .req_sync  (req_sync)
  );

  csr_sel_t sel;
  irq_csr_decode #(.NUM_MBOX(NUM_MBOX)) u_dec (
    .addr (csr_addr),
    .rd   (csr_read),
    .wr   (csr_write),
    .sel  (sel)
  );

  logic [NUM_MBOX-1:0]        mb_clr;
  logic [NUM_MBOX-1:0]        mb_pend;
  logic [NUM_MBOX*CSR_DW-1:0] mb_data;

  always_comb begin
    mb_clr = sel.st_wr ? csr_wdata[MBOX_BIT_BASE +: NUM_MBOX] : '0;
  end

  irq_mbox_bank #(.NUM_MBOX(NUM_MBOX)) u_mbox (
    .clk       (clk),
    .rst_n     (rst_q),
    .wr_en     (sel.mb_wr),
    .wr_idx    (sel.mb_idx),
    .wr_data   (csr_wdata),
    .clr_mask  (mb_clr),
    .pend      (mb_pend),
    .data_flat (mb_data)
  );

  // status word
  logic [CSR_DW-1:0] stat_vec;
  always_comb begin
    stat_vec = '0;
    stat_vec[NUM_REQ-1:0] = req_sync;
    stat_vec[MBOX_BIT_BASE +: NUM_MBOX] = mb_pend;
  end

  // enable word
  logic [CSR_DW-1:0] en_q;
  logic [CSR_DW-1:0] en_d;
  always_comb en_d = csr_wdata & IMPL_MASK;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)        en_q <= '0;
    else if (sel.en_wr) en_q <= en_d;
  end

  // read path
  logic [CSR_DW-1:0] mb_rsel;
  logic [CSR_DW-1:0] rdata_d;
  logic [CSR_DW-1:0] rdata_q;
  always_comb begin
    mb_rsel = '0;
    for (int unsigned i = 0; i < NUM_MBOX; i++)
      if (sel.mb_idx == MBOX_IDX_W'(i)) mb_rsel = mb_data[i*CSR_DW +: CSR_DW];
    unique case (1'b1)
      sel.st_rd: rdata_d = stat_vec;
      sel.en_rd: rdata_d = en_q;
      sel.mb_rd: rdata_d = mb_rsel;
      default:   rdata_d = '0;
    endcase
  end
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)        rdata_q <= '0;
    else if (csr_read) rdata_q <= rdata_d;
  end
  assign csr_rdata = rdata_q;

  // interrupt output
  logic irq_d;
  logic irq_q;
  always_comb irq_d = |(stat_vec & en_q);
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/irq_aggr_checker.sv
module irq_aggr_checker
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_REQ  = 16,
  parameter int unsigned NUM_MBOX = 4
) (
  input logic               clk,
  input logic               rst_q,
  input logic [NUM_REQ-1:0] irq_req_i,
  input logic [CSR_AW-1:0]  csr_addr,
  input logic               csr_read,
  input logic               csr_write,
  input logic [CSR_DW-1:0]  csr_wdata,
  input logic [CSR_DW-1:0]  csr_rdata,
  input logic               irq_o,
  input logic [CSR_DW-1:0]  stat_vec,
  input logic [CSR_DW-1:0]  en_q
);
  localparam logic [CSR_DW-1:0] IMPL_MASK = impl_mask(NUM_REQ, NUM_MBOX);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)         cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (|(stat_vec & en_q)) |=> irq_o);

  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_q)
    !(|(stat_vec & en_q)) |=> !irq_o);

  p_req_track_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (cyc == 2'd3) |-> (stat_vec[NUM_REQ-1:0] == $past(irq_req_i, 2)));

  p_mbox_set_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (csr_write && csr_addr[CSR_AW-1:6] == OFS_MBOX[CSR_AW-1:6] && csr_addr[1:0] == 2'b00
     && csr_addr[5:2] == 4'd0) |=> stat_vec[MBOX_BIT_BASE]);

  p_mbox_w1c_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (csr_write && csr_addr == OFS_STATUS && csr_wdata[MBOX_BIT_BASE]) |=> !stat_vec[MBOX_BIT_BASE]);

  p_mbox_sticky_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (stat_vec[MBOX_BIT_BASE] && !(csr_write && csr_addr == OFS_STATUS)) |=> stat_vec[MBOX_BIT_BASE]);

  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (csr_read && csr_addr == OFS_STATUS) |=> ((csr_rdata & ~IMPL_MASK) == '0));

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !csr_read |=> $stable(csr_rdata));
endmodule

bind irq_aggr_ctrl irq_aggr_checker #(.NUM_REQ(NUM_REQ), .NUM_MBOX(NUM_MBOX)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .irq_req_i (irq_req_i),
  .csr_addr  (csr_addr),
  .csr_read  (csr_read),
  .csr_write (csr_write),
  .csr_wdata (csr_wdata),
  .csr_rdata (csr_rdata),
  .irq_o     (irq_o),
  .stat_vec  (stat_vec),
  .en_q      (en_q)
);

// File: tb/irq_aggr_ctrl_tb.sv
module irq_aggr_ctrl_tb;
  localparam int NREQ  = 5;
  localparam int NMBOX = 3;
  localparam logic [13:0] A_ST = 14'h0040;
  localparam logic [13:0] A_EN = 14'h3070;
  localparam logic [13:0] A_MB = 14'h0900;
  localparam logic [31:0] MASK = 32'h0007_001F;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NREQ-1:0]  req;
  logic [13:0]      addr;
  logic             rd;
  logic             wr;
  logic [31:0]      wdata;
  logic [31:0]      rdata;
  logic             irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_aggr_ctrl #(.NUM_REQ(NREQ), .NUM_MBOX(NMBOX)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req_i(req), .csr_addr(addr),
    .csr_read(rd), .csr_write(wr), .csr_wdata(wdata),
    .csr_rdata(rdata), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(logic [13:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic csr_rd(logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] en_val;
    rst_n = 1'b0; req = '0; addr = '0; rd = 1'b0; wr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 reset rdata", rdata, 32'h0);
    check("R1 reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 irq after release", {31'b0, irq}, 32'h0);
    csr_rd(A_ST, d); check("R1 status after reset", d, 32'h0);
    csr_rd(A_EN, d); check("R1 enable after reset", d, 32'h0);

    // R6 enable mask
    csr_wr(A_EN, 32'hFFFF_FFFF);
    csr_rd(A_EN, d); check("R6 enable readback masked", d, MASK);

    // R2/R7/R9 sweep all request patterns with request enables 0,2,4
    en_val = 32'h0000_0015;
    csr_wr(A_EN, en_val);
    for (int p = 0; p < (1 << NREQ); p++) begin
      @(negedge clk);
      req = NREQ'(p);
      repeat (3) @(negedge clk);
      check("R7 irq level for request pattern", {31'b0, irq}, {31'b0, |(32'(p) & en_val)});
      csr_rd(A_ST, d);
      check("R2 R9 status tracks requests", d, 32'(p));
    end

    // R2 two-edge latency and release
    @(negedge clk); req = '0;
    repeat (3) @(negedge clk);
    @(negedge clk); req = 5'b00100;
    @(negedge clk);
    check("R7 irq not yet after one edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R7 irq still low after two edges", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R2 R7 irq after sync and register", {31'b0, irq}, 32'h1);
    req = '0;
    repeat (3) @(negedge clk);
    check("R2 R7 irq drops with source", {31'b0, irq}, 32'h0);

    // R3 status write does not touch request bits
    @(negedge clk); req = 5'b10011;
    repeat (3) @(negedge clk);
    csr_wr(A_ST, 32'hFFFF_FFFF);
    csr_rd(A_ST, d); check("R3 request bits survive status write", d, 32'h0000_0013);
    @(negedge clk); req = '0;
    repeat (3) @(negedge clk);

    // R4 mailboxes
    for (int i = 0; i < NMBOX; i++) begin
      csr_wr(A_MB + 14'(4*i), 32'hA5C3_0000 + 32'(i * 17));
      csr_rd(A_MB + 14'(4*i), d);
      check("R4 mailbox data readback", d, 32'hA5C3_0000 + 32'(i * 17));
      csr_rd(A_ST, d);
      check("R4 R9 mailbox bits accumulate", d, ((32'h1 << (i + 1)) - 1) << 16);
    end

    // R5 writing zero leaves bits, writing one clears only that bit
    csr_wr(A_ST, 32'h0000_0000);
    csr_rd(A_ST, d); check("R5 zero write keeps mailbox bits", d, 32'h0007_0000);
    csr_wr(A_ST, 32'h0002_0000);
    csr_rd(A_ST, d); check("R5 w1c clears one bit", d, 32'h0005_0000);
    csr_wr(A_ST, 32'h0005_0000);
    csr_rd(A_ST, d); check("R5 w1c clears rest", d, 32'h0);

    // R11 and R8 out-of-range mailbox and unmapped address
    csr_wr(A_MB + 14'(4*NMBOX), 32'hDEAD_BEEF);
    csr_rd(A_ST, d); check("R11 unimplemented mailbox write ignored", d, 32'h0);
    csr_rd(A_MB + 14'(4*NMBOX), d); check("R8 unimplemented mailbox reads zero", d, 32'h0);
    csr_rd(14'h0100, d); check("R8 unmapped reads zero", d, 32'h0);

    // R8 read data holds without a read
    csr_rd(A_EN, d);
    repeat (4) @(negedge clk);
    check("R8 rdata holds between reads", rdata, 32'h0000_0015);

    // R7 timing with a mailbox doorbell
    csr_wr(A_EN, 32'h0001_0000);
    csr_wr(A_MB, 32'h1);
    check("R7 irq low on doorbell edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R7 irq high one edge later", {31'b0, irq}, 32'h1);
    csr_wr(A_ST, 32'h0001_0000);
    check("R7 irq still high on clear edge", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R7 irq low one edge after clear", {31'b0, irq}, 32'h0);

    // R10 unimplemented bits with everything active
    @(negedge clk); req = '1;
    for (int i = 0; i < NMBOX; i++) csr_wr(A_MB + 14'(4*i), 32'h0);
    repeat (3) @(negedge clk);
    csr_rd(A_ST, d); check("R10 R9 only implemented bits set", d, MASK);

    finish_run();
  end
endmodule